// File: doc/BRIEF.md
# Waveform Start and Update Sequencer

This block paces analog-output waveform playback. A start trigger and an update strobe each come from one pin of a bank of general-purpose trigger inputs. Separate selector and polarity controls pick the pin and the active edge for each signal. Every input passes through a two-flop synchronizer and an edge stage. The first accepted start edge puts the block into its running state.

While the block runs, converter updates come from one of two sources. In internal mode, a reloadable interval counter emits one update every `D` clocks, where `D` is the programmed divisor with a floor of two. In external mode, the selected update pin supplies the updates, and only while the converters are in posted-update mode. A software stop or a buffer-complete indication ends the run. Update events outside a run are dropped.

Two output pins echo what actually happened. One carries an active-high start pulse for each start that was accepted. The other carries an active-low pulse for each update applied to the converters. Each pulse width is derived from nanosecond limits and the clock period. Both pins stay undriven after reset until their drive enable is set.

Top module: `wfm_seq_ctrl`

## Requirements
- R1: A start is accepted only on the chosen edge of the pin picked by `start_sel`, where `start_fall`=0 selects rising and 1 selects falling. Other pins and the opposite edge cause no start. `start_out` rises three clocks after the pin changes.
- R2: `running` goes high on the clock that accepts a start and stays high until a stop.
- R3: In internal mode (`upd_ext`=0), the first `dac_update` comes D-1 clocks after `start_out` rises. Later ones follow every D clocks. D is the divisor value taken at each reload.
- R4: A divisor of 0 or 1 acts as D=2, so internal updates are never on adjacent clocks.
- R5: In external mode with `posted_mode`=1 and `running` high, each chosen edge on the pin picked by `upd_sel` gives exactly one `dac_update`, two clocks after the pin changes. `upd_fall` sets the edge polarity the same way `start_fall` does. The opposite edge is ignored, and the interval counter makes no updates in this mode.
- R6: With `posted_mode`=0, external update edges produce no `dac_update`.
- R7: Update events while `running` is low are ignored.
- R8: `sw_stop` or `buf_done` while running clears `running` on the next clock. No `dac_update` follows.
- R9: `start_out` is high for START_CYC = ceil(START_NS/CLK_NS) clocks per accepted start. Start edges during a run produce no pulse.
- R10: `upd_out_n` is low for UPD_CYC = ceil(UPD_NS/CLK_NS) clocks, beginning the clock after each `dac_update`.
- R11: `pins_oe` is low after reset and follows `out_en` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfi_in | input | NUM_PINS | Trigger input pin bank |
| start_sel | input | SEL_W | Pin index of the start trigger |
| start_fall | input | 1 | Start edge: 0 rising, 1 falling |
| upd_sel | input | SEL_W | Pin index of the external update strobe |
| upd_fall | input | 1 | Update edge: 0 rising, 1 falling |
| upd_ext | input | 1 | 1 selects external updates, 0 selects the interval counter |
| posted_mode | input | 1 | Converters accept external updates when 1 |
| divisor | input | DIV_W | Interval counter period in clocks |
| sw_stop | input | 1 | Software stop request |
| buf_done | input | 1 | Buffer counter completion |
| out_en | input | 1 | Drive enable for both output pins |
| dac_update | output | 1 | One-clock update strobe to the converters |
| running | output | 1 | High between start and stop |
| start_out | output | 1 | Start echo pulse, active high |
| upd_out_n | output | 1 | Update echo pulse, active low |
| pins_oe | output | 1 | Output enable for both echo pins |

## Verification
The bench targets divisors of 0, 1 and 2, where a missing clamp would emit updates every clock or stall the counter. An off-by-one reload would shift the first update or the period by one clock. It changes pins that are not selected and drives the opposite edge. A wrong mux index or an inverted polarity would start a run or an update spuriously. It fires update edges before the start, after the stop and with posted mode cleared, which catches a gate missing from the update path. It also repeats the start edge during a run, where an echo taken from the raw edge rather than the accepted start would give an extra `start_out` pulse.

// File: rtl/wfm_seq_pkg.sv
package wfm_seq_pkg;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_pol_t;

  // Number of clocks needed to cover at least min_ns, never fewer than one.
  function automatic int unsigned pulse_cycles(int unsigned min_ns, int unsigned clk_ns);
    int unsigned r;
    r = (min_ns + clk_ns - 1) / clk_ns;
    if (r == 0) r = 1;
    return r;
  endfunction

  // Effective interval period: anything under two becomes two.
  function automatic int unsigned eff_div(int unsigned d);
    return (d < 2) ? 2 : d;
  endfunction

endpackage

// File: rtl/pin_edge_sel.sv
module pin_edge_sel #(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [SEL_W-1:0]    sel,
  input  logic                fall,
  output logic                evt
);
  import wfm_seq_pkg::*;

  logic picked;
  logic s1, s2, prev;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NUM_PINS; i++)
      if (sel == SEL_W'(i)) picked = pins[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= picked;
      s2   <= s1;
      prev <= s2;
    end
  end

  // Edge present when the synchronized level moved; polarity picks the direction.
  assign evt = (s2 != prev) && (s2 == (edge_pol_t'(fall) == EDGE_RISE));

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  import wfm_seq_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = DIV_W'(eff_div(32'(divisor)) - 1);
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= reload;
    else if (run)    cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

endmodule

// File: rtl/wfm_seq_ctrl.sv
module wfm_seq_ctrl #(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = $clog2(NUM_PINS),
  parameter int DIV_W    = 16,
  parameter int CLK_NS   = 10,
  parameter int START_NS = 25,
  parameter int UPD_NS   = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pfi_in,
  input  logic [SEL_W-1:0]    start_sel,
  input  logic                start_fall,
  input  logic [SEL_W-1:0]    upd_sel,
  input  logic                upd_fall,
  input  logic                upd_ext,
  input  logic                posted_mode,
  input  logic [DIV_W-1:0]    divisor,
  input  logic                sw_stop,
  input  logic                buf_done,
  input  logic                out_en,
  output logic                dac_update,
  output logic                running,
  output logic                start_out,
  output logic                upd_out_n,
  output logic                pins_oe
);
  import wfm_seq_pkg::*;

  localparam int START_CYC = int'(pulse_cycles(START_NS, CLK_NS));
  localparam int UPD_CYC   = int'(pulse_cycles(UPD_NS, CLK_NS));

  // Named internal events, visible to the bound checker.
  logic start_edge, upd_edge;
  logic start_evt, stop_req, tick, ext_fire, upd_active;

  pin_edge_sel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_start_in (
    .clk(clk), .rst_n(rst_n), .pins(pfi_in), .sel(start_sel),
    .fall(start_fall), .evt(start_edge)
  );

  pin_edge_sel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_upd_in (
    .clk(clk), .rst_n(rst_n), .pins(pfi_in), .sel(upd_sel),
    .fall(upd_fall), .evt(upd_edge)
  );

  assign start_evt = start_edge && !running;
  assign stop_req  = running && (sw_stop || buf_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         running <= 1'b0;
    else if (start_evt) running <= 1'b1;
    else if (stop_req)  running <= 1'b0;
  end

  interval_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start_evt),
    .run(running && !upd_ext), .divisor(divisor), .tick(tick)
  );

  assign ext_fire   = upd_edge && posted_mode;
  assign dac_update = running && !stop_req && (upd_ext ? ext_fire : tick);

  pulse_shaper #(.CYC(START_CYC)) u_start_pw (
    .clk(clk), .rst_n(rst_n), .trig(start_evt), .active(start_out)
  );

  pulse_shaper #(.CYC(UPD_CYC)) u_upd_pw (
    .clk(clk), .rst_n(rst_n), .trig(dac_update), .active(upd_active)
  );

  assign upd_out_n = !upd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_oe <= 1'b0;
    else        pins_oe <= out_en;
  end

endmodule

// File: rtl/wfm_seq_chk.sv
module wfm_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic sw_stop,
  input logic buf_done,
  input logic upd_ext,
  input logic out_en,
  input logic dac_update,
  input logic running,
  input logic start_out,
  input logic upd_out_n,
  input logic pins_oe
);

  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> running);

  assert_no_adjacent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_update && !upd_ext) |=> (upd_ext || !dac_update));

  assert_update_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_update |-> running);

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (sw_stop || buf_done)) |=> !running);

  assert_start_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_out) |-> (running && !$past(running)));

  assert_update_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_out_n) |-> $past(dac_update));

  assert_oe_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !pins_oe);

endmodule

bind wfm_seq_ctrl wfm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .sw_stop(sw_stop),
  .buf_done(buf_done), .upd_ext(upd_ext), .out_en(out_en),
  .dac_update(dac_update), .running(running), .start_out(start_out),
  .upd_out_n(upd_out_n), .pins_oe(pins_oe)
);

// File: tb/wfm_seq_ctrl_test.sv
module wfm_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 8;
  localparam int SW   = 3;
  localparam int DW   = 16;
  localparam int CNS  = 10;
  localparam int SNS  = 25;
  localparam int UNS  = 50;

  function automatic int ceil_cyc(int ns, int c);
    int r;
    r = ns / c;
    if (r * c < ns) r = r + 1;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int period_of(int d);
    return (d <= 1) ? 2 : d;
  endfunction

  localparam int START_CYC = ceil_cyc(SNS, CNS);
  localparam int UPD_CYC   = ceil_cyc(UNS, CNS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pfi_in = '0;
  logic [SW-1:0] start_sel = '0, upd_sel = '0;
  logic start_fall = 1'b0, upd_fall = 1'b0, upd_ext = 1'b0, posted_mode = 1'b1;
  logic [DW-1:0] divisor = '0;
  logic sw_stop = 1'b0, buf_done = 1'b0, out_en = 1'b0;
  logic dac_update, running, start_out, upd_out_n, pins_oe;

  wfm_seq_ctrl #(.NUM_PINS(NP), .SEL_W(SW), .DIV_W(DW), .CLK_NS(CNS),
                 .START_NS(SNS), .UPD_NS(UNS)) uut (
    .clk(clk), .rst_n(rst_n), .pfi_in(pfi_in), .start_sel(start_sel),
    .start_fall(start_fall), .upd_sel(upd_sel), .upd_fall(upd_fall),
    .upd_ext(upd_ext), .posted_mode(posted_mode), .divisor(divisor),
    .sw_stop(sw_stop), .buf_done(buf_done), .out_en(out_en),
    .dac_update(dac_update), .running(running), .start_out(start_out),
    .upd_out_n(upd_out_n), .pins_oe(pins_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0, upd_count = 0, start_rises = 0, start_rise_cyc = 0;
  int hirun = 0, last_hi = 0, lowrun = 0, last_low = 0;
  int upd_cyc [16];
  logic prev_start = 1'b0;

  // Monitor samples outputs on the falling edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (dac_update) begin
        upd_cyc[upd_count % 16] = cyc;
        upd_count = upd_count + 1;
      end
      if (start_out && !prev_start) begin
        start_rises = start_rises + 1;
        start_rise_cyc = cyc;
      end
      if (start_out) hirun = hirun + 1;
      else if (hirun != 0) begin last_hi = hirun; hirun = 0; end
      if (!upd_out_n) lowrun = lowrun + 1;
      else if (lowrun != 0) begin last_low = lowrun; lowrun = 0; end
      prev_start = start_out;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reconfigure with stop held so that any stray edge cannot leave a run open.
  task automatic reconfig(int sp, bit sf, int up, bit uf, bit ext);
    sw_stop = 1'b1;
    pfi_in = '0;
    pfi_in[sp] = sf;
    if (up != sp) pfi_in[up] = uf;
    step(5);
    start_fall = sf; upd_fall = uf; start_sel = SW'(sp); upd_sel = SW'(up);
    upd_ext = ext;
    step(5);
    sw_stop = 1'b0;
    step(2);
  endtask

  task automatic run_internal(int pin, bit fall, int div, bit use_buf);
    int d, ub, r0, other, uc;
    d = period_of(div);
    divisor = DW'(div);
    reconfig(pin, fall, (pin + 1) % NP, 1'b0, 1'b0);
    check(running == 1'b0, "R2 idle before start", running, 0);
    other = (pin + 1 + int'($urandom % (NP - 1))) % NP;
    r0 = start_rises;
    pfi_in[other] = ~pfi_in[other];
    step(5);
    pfi_in[other] = ~pfi_in[other];
    step(5);
    check(start_rises == r0 && !running, "R1 other pin ignored", start_rises - r0, 0);
    ub = upd_count;
    pfi_in[pin] = ~pfi_in[pin];
    step(2);
    check(start_out == 1'b0, "R1 start latency early", start_out, 0);
    step(1);
    check(start_out == 1'b1, "R1 start latency", start_out, 1);
    check(running == 1'b1, "R2 running after start", running, 1);
    for (int w = 0; w < 200 && upd_count < ub + 4; w++) step(1);
    step(START_CYC + 2);
    check(last_hi == START_CYC, "R9 start pulse width", last_hi, START_CYC);
    check(upd_cyc[ub % 16] == start_rise_cyc + d - 1, "R3 first update",
          upd_cyc[ub % 16] - start_rise_cyc, d - 1);
    check(upd_cyc[(ub + 1) % 16] - upd_cyc[ub % 16] == d,
          (div < 2) ? "R4 clamped period" : "R3 period",
          upd_cyc[(ub + 1) % 16] - upd_cyc[ub % 16], d);
    check(upd_cyc[(ub + 2) % 16] - upd_cyc[(ub + 1) % 16] == d, "R3 steady period",
          upd_cyc[(ub + 2) % 16] - upd_cyc[(ub + 1) % 16], d);
    if (d >= UPD_CYC + 2)
      check(last_low == UPD_CYC, "R10 update pulse width", last_low, UPD_CYC);
    r0 = start_rises;
    pfi_in[pin] = ~pfi_in[pin];
    step(4);
    pfi_in[pin] = ~pfi_in[pin];
    step(4);
    check(start_rises == r0, "R9 restart during run ignored", start_rises - r0, 0);
    if (use_buf) buf_done = 1'b1; else sw_stop = 1'b1;
    step(1);
    buf_done = 1'b0; sw_stop = 1'b0;
    check(running == 1'b0, "R8 stop clears running", running, 0);
    uc = upd_count;
    step(3 * d + 6);
    check(upd_count == uc, "R8 no update after stop", upd_count - uc, 0);
  endtask

  task automatic run_external(int sp, int up, bit sf, bit uf);
    int uc, r0;
    reconfig(sp, sf, up, uf, 1'b1);
    posted_mode = 1'b1;
    divisor = DW'(3);
    uc = upd_count;
    pfi_in[up] = ~pfi_in[up];
    step(5);
    pfi_in[up] = ~pfi_in[up];
    step(5);
    check(upd_count == uc, "R7 update before start ignored", upd_count - uc, 0);
    r0 = start_rises;
    pfi_in[sp] = ~pfi_in[sp];
    step(4);
    check(running == 1'b1 && start_rises == r0 + 1, "R2 external run started",
          start_rises - r0, 1);
    step(20);
    check(upd_count == uc, "R5 counter silent in external mode", upd_count - uc, 0);
    for (int k = 0; k < 3; k++) begin
      uc = upd_count;
      pfi_in[up] = ~pfi_in[up];
      step(1);
      check(upd_count == uc, "R5 update latency early", upd_count - uc, 0);
      step(1);
      check(upd_count == uc + 1, "R5 external update", upd_count - uc, 1);
      step(UPD_CYC + 2);
      check(last_low == UPD_CYC, "R10 external update width", last_low, UPD_CYC);
      pfi_in[up] = ~pfi_in[up];
      step(4);
      check(upd_count == uc + 1, "R5 opposite edge ignored", upd_count - uc, 1);
    end
    posted_mode = 1'b0;
    uc = upd_count;
    pfi_in[up] = ~pfi_in[up];
    step(5);
    pfi_in[up] = ~pfi_in[up];
    step(5);
    check(upd_count == uc, "R6 not posted ignored", upd_count - uc, 0);
    posted_mode = 1'b1;
    buf_done = 1'b1;
    step(1);
    buf_done = 1'b0;
    check(running == 1'b0, "R8 buffer done stops", running, 0);
    uc = upd_count;
    pfi_in[up] = ~pfi_in[up];
    step(5);
    check(upd_count == uc, "R7 update after stop ignored", upd_count - uc, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures = failures + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    rst_n = 1'b1;
    step(1);
    check(pins_oe == 1'b0, "R11 oe low after reset", pins_oe, 0);
    check(running == 1'b0 && start_out == 1'b0, "R2 reset idle", running, 0);
    check(upd_out_n == 1'b1 && dac_update == 1'b0, "R10 reset update idle", upd_out_n, 1);
    out_en = 1'b1;
    step(1);
    check(pins_oe == 1'b1, "R11 oe follows enable", pins_oe, 1);
    out_en = 1'b0;
    step(1);
    check(pins_oe == 1'b0, "R11 oe drops", pins_oe, 0);
    out_en = 1'b1;
    run_internal(2, 1'b0, 0, 1'b0);
    run_internal(5, 1'b1, 1, 1'b1);
    run_internal(0, 1'b0, 2, 1'b0);
    run_internal(7, 1'b1, 10, 1'b1);
    for (int t = 0; t < 8; t++)
      run_internal(int'($urandom % NP), 1'($urandom % 2), int'($urandom % 13),
                   1'($urandom % 2));
    run_external(1, 4, 1'b0, 1'b0);
    run_external(6, 3, 1'b1, 1'b1);
    run_external(0, 7, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule